// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction Processor Core

The block is a 32-bit processor core that retires one instruction on every clock edge. An instruction is fetched at the program counter. Its registers are read and the arithmetic or address result is formed. Data memory is read or written, and the register result is written back. All of this takes place inside one cycle. The core runs nine instructions: five register-to-register operations (add, sub, and, or, slt), a word load and a word store, a branch on equal, and an absolute jump.

Program and data storage are word arrays inside the block. While reset is held, a load port writes words into either array, and the core runs from address 0 once reset is released. During execution the core never writes the instruction array. Each retiring instruction is shown on the ports: its PC and instruction word, any register write-back (enable, index, value) and any data-memory store (enable, byte address, value). The ALU result is always on the address port.

Top module: `mlite_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and no register or memory write is reported. Reset assertion takes effect at once. After release, the first instruction (at PC 0) executes on the third rising edge.
- R2: R-format words are op=0 in [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0]. Funct 32 (add), 34 (sub = rs-rt), 36 (and) and 37 (or) write their result to rd.
- R3: Funct 42 (slt) writes 1 to rd when rs < rt as signed 32-bit values, otherwise 0.
- R4: Opcode 35 (load) forms the byte address rs + sign-extended imm[15:0] on `dmem_addr_o`. It writes the word at that address into rt (field [20:16]).
- R5: Opcode 43 (store) writes rt's value to the word at rs + sign-extended imm. It writes no register.
- R6: Opcode 4 (beq) writes nothing. When rs equals rt, the next PC is PC+4 + (sign-extended imm << 2). Otherwise it is PC+4.
- R7: Opcode 2 (jump) writes nothing. The next PC is {(PC+4)[31:28], instr[25:0], 2'b00}.
- R8: Every instruction other than a taken branch or a jump advances the PC by 4.
- R9: Register 0 reads as zero. A write aimed at it is dropped and is not reported on `rf_we_o`.
- R10: Any other opcode, and any R-format funct outside {32,34,36,37,42}, writes neither a register nor memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| load_we | input | 1 | Write strobe of the load port |
| load_dmem | input | 1 | Load target: 0 program array, 1 data array |
| load_addr | input | MEM_AW | Word index for the load port |
| load_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | PC of the retiring instruction |
| instr_o | output | 32 | Instruction word being executed |
| rf_we_o | output | 1 | Register write-back this cycle |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Value written back |
| dmem_we_o | output | 1 | Data store this cycle |
| dmem_addr_o | output | 32 | ALU result, used as the data byte address |
| dmem_wdata_o | output | 32 | Value of rt, the store data |

## Verification
Every write-back and store result is combinational from the PC register. It therefore belongs to the same cycle as the instruction on `pc_o`, and the PC after it appears one rising edge later. The bench samples on the falling edge between two rising edges and compares the instruction shown there against its vector. The next vector row is then taken one falling edge later. The row thus checks branch and jump targets through the PC that comes next. After reset is released, the bench waits two falling edges for the synchroniser before it takes the first row.

// File: rtl/mlite_pkg.sv
`timescale 1ns/1ps
package mlite_pkg;
  localparam int XLEN  = 32;
  localparam int RF_N  = 32;
  localparam int RF_AW = $clog2(RF_N);

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;     // destination from rd instead of rt
    logic    b_imm;      // ALU operand B from immediate
    logic    wb_mem;     // write-back from data memory
    logic    rf_write;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/mlite_decode.sv
`timescale 1ns/1ps
module mlite_decode
  import mlite_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        case (funct)
          FN_ADD: begin ctrl.rf_write = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl.rf_write = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_AND: begin ctrl.rf_write = 1'b1; ctrl.alu_op = ALU_AND; end
          FN_OR:  begin ctrl.rf_write = 1'b1; ctrl.alu_op = ALU_OR;  end
          FN_SLT: begin ctrl.rf_write = 1'b1; ctrl.alu_op = ALU_SLT; end
          default: ctrl.rf_write = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.b_imm    = 1'b1;
        ctrl.wb_mem   = 1'b1;
        ctrl.rf_write = 1'b1;
      end
      OP_STORE: begin
        ctrl.b_imm     = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ctrl.rf_write = 1'b0;
    endcase
  end
endmodule

// File: rtl/mlite_alu.sv
`timescale 1ns/1ps
module mlite_alu
  import mlite_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/mlite_regfile.sv
`timescale 1ns/1ps
module mlite_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [NREG-1:0][W-1:0] regs;

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic         en;
    logic [W-1:0] q;
    assign en = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign regs[g] = q;
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/mlite_core.sv
`timescale 1ns/1ps
module mlite_core
  import mlite_pkg::*;
#(
  parameter int MEM_AW = 6,
  localparam int MEM_DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_we,
  input  logic              load_dmem,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [XLEN-1:0]   load_data,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   instr_o,
  output logic              rf_we_o,
  output logic [RF_AW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              dmem_we_o,
  output logic [XLEN-1:0]   dmem_addr_o,
  output logic [XLEN-1:0]   dmem_wdata_o
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync;
  logic       run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign run = rst_sync[1];

  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] imem [MEM_DEPTH];
  logic [XLEN-1:0] dmem [MEM_DEPTH];
  logic [XLEN-1:0] instr;

  always_ff @(posedge clk) begin
    if (load_we && !load_dmem) imem[load_addr] <= load_data;
  end
  assign instr = imem[pc_q[MEM_AW+1:2]];

  // field split
  logic [5:0]       opcode, funct;
  logic [RF_AW-1:0] rs, rt, rd;
  logic [15:0]      imm;
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];
  assign imm    = instr[15:0];

  ctrl_t ctrl;
  mlite_decode u_dec (.opcode(opcode), .funct(funct), .ctrl(ctrl));

  logic             wr_en;
  logic [RF_AW-1:0] wr_idx;
  logic [XLEN-1:0]  wr_val, rs_val, rt_val;

  mlite_regfile #(.W(XLEN), .NREG(RF_N)) u_rf (
    .clk(clk), .rst_n(run), .we(wr_en), .waddr(wr_idx), .wdata(wr_val),
    .ra1(rs), .ra2(rt), .rd1(rs_val), .rd2(rt_val)
  );

  logic [XLEN-1:0] sext, alu_b, alu_y, mem_rd;
  logic            alu_zero;
  assign sext  = {{(XLEN-16){imm[15]}}, imm};
  assign alu_b = ctrl.b_imm ? sext : rt_val;

  mlite_alu #(.W(XLEN)) u_alu (
    .a(rs_val), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .zero(alu_zero)
  );

  logic mem_wr;
  assign mem_wr = run && ctrl.mem_write;
  always_ff @(posedge clk) begin
    if (load_we && load_dmem) dmem[load_addr]           <= load_data;
    else if (mem_wr)          dmem[alu_y[MEM_AW+1:2]]   <= rt_val;
  end
  assign mem_rd = dmem[alu_y[MEM_AW+1:2]];

  // write-back selection; index 0 is never written
  assign wr_idx = ctrl.dst_rd ? rd : rt;
  assign wr_val = ctrl.wb_mem ? mem_rd : alu_y;
  assign wr_en  = run && ctrl.rf_write && (wr_idx != '0);

  // next-PC selection
  logic [XLEN-1:0] pc_inc, pc_br, pc_jmp;
  logic            take_br;
  assign pc_inc  = pc_q + XLEN'(4);
  assign pc_br   = pc_inc + {sext[XLEN-3:0], 2'b00};
  assign pc_jmp  = {pc_inc[XLEN-1:XLEN-4], instr[25:0], 2'b00};
  assign take_br = ctrl.branch && alu_zero;

  always_comb begin
    if (ctrl.jump)    pc_d = pc_jmp;
    else if (take_br) pc_d = pc_br;
    else              pc_d = pc_inc;
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run) pc_q <= '0;
    else      pc_q <= pc_d;
  end

  assign pc_o         = pc_q;
  assign instr_o      = instr;
  assign rf_we_o      = wr_en;
  assign rf_waddr_o   = wr_idx;
  assign rf_wdata_o   = wr_val;
  assign dmem_we_o    = mem_wr;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_val;
endmodule

// File: rtl/mlite_core_chk.sv
`timescale 1ns/1ps
module mlite_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [31:0] pc_o,
  input logic [31:0] instr_o,
  input logic        rf_we_o,
  input logic [4:0]  rf_waddr_o,
  input logic        dmem_we_o
);
  logic [5:0]  op, fn;
  logic [31:0] seq_pc, br_pc, jmp_pc;
  logic        known;
  assign op     = instr_o[31:26];
  assign fn     = instr_o[5:0];
  assign seq_pc = pc_o + 32'd4;
  assign br_pc  = seq_pc + {{14{instr_o[15]}}, instr_o[15:0], 2'b00};
  assign jmp_pc = {seq_pc[31:28], instr_o[25:0], 2'b00};
  assign known  = (op == 6'd0 && (fn == 6'd32 || fn == 6'd34 || fn == 6'd36 ||
                                  fn == 6'd37 || fn == 6'd42)) ||
                  op == 6'd35 || op == 6'd43 || op == 6'd4 || op == 6'd2;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_pc_reset_r1: assert (pc_o == 32'd0 && !rf_we_o && !dmem_we_o);
    end
  end

  p_store_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 6'd43) |-> (dmem_we_o && !rf_we_o));

  p_branch_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 6'd4) |=> (pc_o == $past(seq_pc) || pc_o == $past(br_pc)));

  p_jump_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 6'd2) |=> (pc_o == $past(jmp_pc)));

  p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op != 6'd4 && op != 6'd2) |=> (pc_o == $past(seq_pc)));

  p_zero_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_waddr_o != 5'd0));

  p_unknown_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !known) |-> (!rf_we_o && !dmem_we_o));
endmodule

bind mlite_core mlite_core_chk i_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pc_o(pc_o), .instr_o(instr_o),
  .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .dmem_we_o(dmem_we_o)
);

// File: tb/test_mlite_core.sv
`timescale 1ns/1ps
module test_mlite_core;
  localparam int MEM_AW = 6;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int NPROG  = 31;
  localparam int NVEC   = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              load_we, load_dmem;
  logic [MEM_AW-1:0] load_addr;
  logic [31:0]       load_data;
  logic [31:0]       pc_o, instr_o, rf_wdata_o, dmem_addr_o, dmem_wdata_o;
  logic              rf_we_o, dmem_we_o;
  logic [4:0]        rf_waddr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mlite_core #(.MEM_AW(MEM_AW)) i_mlite_core (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data), .pc_o(pc_o),
    .instr_o(instr_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o), .dmem_we_o(dmem_we_o),
    .dmem_addr_o(dmem_addr_o), .dmem_wdata_o(dmem_wdata_o)
  );

  function automatic logic [31:0] enc_r(int s, int t, int d, int f);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'(f)};
  endfunction
  function automatic logic [31:0] enc_i(int o, int s, int t, logic [15:0] v);
    return {6'(o), 5'(s), 5'(t), v};
  endfunction
  function automatic logic [31:0] enc_j(int w);
    return {6'd2, 26'(w)};
  endfunction

  localparam logic [31:0] PROG [NPROG] = '{
    enc_i(35, 0, 1, 16'd0),        // 0  pc0   load r1 <- [0]
    enc_i(35, 0, 2, 16'd4),        // 1  pc4   load r2 <- [4]
    enc_i(35, 0, 3, 16'd8),        // 2  pc8   load r3 <- [8]
    enc_r(1, 2, 4, 32),            // 3  pc12  add
    enc_r(1, 2, 5, 34),            // 4  pc16  sub
    enc_r(3, 2, 6, 36),            // 5  pc20  and
    enc_r(4, 5, 7, 37),            // 6  pc24  or
    enc_r(2, 1, 8, 42),            // 7  pc28  slt -3<5
    enc_r(1, 2, 9, 42),            // 8  pc32  slt 5<-3
    enc_r(1, 1, 0, 32),            // 9  pc36  add into r0
    enc_i(43, 5, 1, 16'd16),       // 10 pc40  store r1 -> [24]
    enc_i(35, 5, 10, 16'd16),      // 11 pc44  load r10 <- [24]
    enc_r(0, 1, 11, 32),           // 12 pc48  add r0+r1
    enc_i(4, 1, 10, 16'd2),        // 13 pc52  beq taken -> 64
    enc_r(1, 1, 12, 32),           // 14 skipped
    enc_r(1, 1, 12, 32),           // 15 skipped
    enc_i(4, 1, 2, 16'd5),         // 16 pc64  beq not taken
    enc_i(43, 5, 7, 16'hFFF8),     // 17 pc68  store r7 -> [0]
    enc_i(35, 0, 13, 16'd0),       // 18 pc72  load r13 <- [0]
    enc_i(8, 1, 14, 16'd100),      // 19 pc76  unknown opcode
    enc_r(1, 2, 15, 0),            // 20 pc80  unknown funct
    enc_j(28),                     // 21 pc84  jump -> 112
    32'd0, 32'd0, 32'd0,           // 22..24
    enc_r(8, 11, 16, 32),          // 25 pc100 add
    enc_j(30),                     // 26 pc104 jump -> 120
    32'd0,                         // 27
    enc_i(4, 0, 0, 16'hFFFC),      // 28 pc112 beq back -> 100
    32'd0,                         // 29
    enc_r(2, 1, 17, 34)            // 30 pc120 sub
  };

  typedef struct packed {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        mwe;
    logic        mchk;
    logic [31:0] ma;
    logic [31:0] md;
  } vec_t;

  // pc, rf write, index, value, store, check address, address, store data
  localparam vec_t VEC [NVEC] = '{
    '{32'd0,   1'b1, 5'd1,  32'd5,        1'b0, 1'b1, 32'd0,  32'd0}, // R4
    '{32'd4,   1'b1, 5'd2,  32'hFFFFFFFD, 1'b0, 1'b1, 32'd4,  32'd0}, // R4
    '{32'd8,   1'b1, 5'd3,  32'h0F0F00FF, 1'b0, 1'b1, 32'd8,  32'd0}, // R4
    '{32'd12,  1'b1, 5'd4,  32'd2,        1'b0, 1'b0, 32'd0,  32'd0}, // R2 add
    '{32'd16,  1'b1, 5'd5,  32'd8,        1'b0, 1'b0, 32'd0,  32'd0}, // R2 sub
    '{32'd20,  1'b1, 5'd6,  32'h0F0F00FD, 1'b0, 1'b0, 32'd0,  32'd0}, // R2 and
    '{32'd24,  1'b1, 5'd7,  32'd10,       1'b0, 1'b0, 32'd0,  32'd0}, // R2 or
    '{32'd28,  1'b1, 5'd8,  32'd1,        1'b0, 1'b0, 32'd0,  32'd0}, // R3
    '{32'd32,  1'b1, 5'd9,  32'd0,        1'b0, 1'b0, 32'd0,  32'd0}, // R3
    '{32'd36,  1'b0, 5'd0,  32'd0,        1'b0, 1'b0, 32'd0,  32'd0}, // R9
    '{32'd40,  1'b0, 5'd0,  32'd0,        1'b1, 1'b1, 32'd24, 32'd5}, // R5
    '{32'd44,  1'b1, 5'd10, 32'd5,        1'b0, 1'b1, 32'd24, 32'd0}, // R4
    '{32'd48,  1'b1, 5'd11, 32'd5,        1'b0, 1'b0, 32'd0,  32'd0}, // R9
    '{32'd52,  1'b0, 5'd0,  32'd0,        1'b0, 1'b0, 32'd0,  32'd0}, // R6
    '{32'd64,  1'b0, 5'd0,  32'd0,        1'b0, 1'b0, 32'd0,  32'd0}, // R6
    '{32'd68,  1'b0, 5'd0,  32'd0,        1'b1, 1'b1, 32'd0,  32'd10}, // R5 R8
    '{32'd72,  1'b1, 5'd13, 32'd10,       1'b0, 1'b1, 32'd0,  32'd0}, // R4
    '{32'd76,  1'b0, 5'd0,  32'd0,        1'b0, 1'b0, 32'd0,  32'd0}, // R10
    '{32'd80,  1'b0, 5'd0,  32'd0,        1'b0, 1'b0, 32'd0,  32'd0}, // R10
    '{32'd84,  1'b0, 5'd0,  32'd0,        1'b0, 1'b0, 32'd0,  32'd0}, // R7 R8
    '{32'd112, 1'b0, 5'd0,  32'd0,        1'b0, 1'b0, 32'd0,  32'd0}, // R7 R6
    '{32'd100, 1'b1, 5'd16, 32'd6,        1'b0, 1'b0, 32'd0,  32'd0}, // R6 R2
    '{32'd104, 1'b0, 5'd0,  32'd0,        1'b0, 1'b0, 32'd0,  32'd0}, // R7
    '{32'd120, 1'b1, 5'd17, 32'hFFFFFFF8, 1'b0, 1'b0, 32'd0,  32'd0}  // R7 R2
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load_word(input logic sel, input int idx, input logic [31:0] val);
    @(negedge clk);
    load_we   = 1'b1;
    load_dmem = sel;
    load_addr = MEM_AW'(idx);
    load_data = val;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_we = 1'b0; load_dmem = 1'b0; load_addr = '0; load_data = '0;
    for (int i = 0; i < DEPTH; i++) load_word(1'b0, i, (i < NPROG) ? PROG[i] : 32'd0);
    for (int i = 0; i < DEPTH; i++) begin
      case (i)
        0:       load_word(1'b1, i, 32'd5);
        1:       load_word(1'b1, i, 32'hFFFFFFFD);
        2:       load_word(1'b1, i, 32'h0F0F00FF);
        default: load_word(1'b1, i, 32'd0);
      endcase
    end
    @(negedge clk);
    load_we = 1'b0;

    // R1: state held in reset
    chk("R1", "pc in reset", pc_o, 32'd0);
    chk("R1", "rf_we in reset", {31'd0, rf_we_o}, 32'd0);
    chk("R1", "dmem_we in reset", {31'd0, dmem_we_o}, 32'd0);

    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      chk("R8", $sformatf("vec%0d pc", k), pc_o, VEC[k].pc);
      chk("R2", $sformatf("vec%0d rf_we", k), {31'd0, rf_we_o}, {31'd0, VEC[k].we});
      if (VEC[k].we) begin
        chk("R2", $sformatf("vec%0d waddr", k), {27'd0, rf_waddr_o}, {27'd0, VEC[k].wa});
        chk("R2", $sformatf("vec%0d wdata", k), rf_wdata_o, VEC[k].wd);
      end
      chk("R5", $sformatf("vec%0d dmem_we", k), {31'd0, dmem_we_o}, {31'd0, VEC[k].mwe});
      if (VEC[k].mchk)
        chk("R4", $sformatf("vec%0d addr", k), dmem_addr_o, VEC[k].ma);
      if (VEC[k].mwe)
        chk("R5", $sformatf("vec%0d store data", k), dmem_wdata_o, VEC[k].md);
      @(negedge clk);
    end

    // R1: asynchronous reset in mid-run
    #2 rst_n = 1'b0;
    #1;
    chk("R1", "pc at async reset", pc_o, 32'd0);
    chk("R1", "rf_we at async reset", {31'd0, rf_we_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "no write during release", {31'd0, rf_we_o}, 32'd0);
    @(negedge clk);
    chk("R1", "pc after restart", pc_o, 32'd0);
    // R4: data memory keeps the value stored before the reset
    chk("R4", "reload word 0", rf_wdata_o, 32'd10);
    chk("R4", "reload rf_we", {31'd0, rf_we_o}, 32'd1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule